// File: doc/BRIEF.md
# DQS Read Gate Window Generator

This block generates the read strobe gate for one byte lane of a DDR memory interface. All timing uses half clock period steps. A qualifying tick input (`tick_i`) marks each step, and the block does nothing on clock edges where that tick is low. When a read is issued, the block schedules the gate to open at the programmed read latency. It can move the opening half a period earlier and widen the closing side by a coded amount. The opening is never moved ahead of the zero-latency point.

The gate closes in one of two ways:

- **Counting mode.** The block counts synchronized DQS rising edges and shuts the gate on its own after the expected number of edges.
- **External mode.** The block follows a close pulse from the surrounding training or control logic.

Reads that arrive while a window is still pending or open add their strobe edges to the current window instead of starting a new one. A small configuration register holds the extension mode and the counting choice. It resets to counting mode with no extension.

Top module: `dqs_gate_gen`

## Requirements
- R1: After reset the gate output is 0, the extension mode is 00 and counting mode is selected, so a read issued without any configuration write behaves as mode 00 with counting.
- R2: A read sampled on tick t0 while idle opens the gate after tick t0 + 2*lat - e, where e = 1 when the extension mode is non-zero and lat is non-zero, and e = 0 otherwise. A result of 0 opens the gate on tick t0 itself.
- R3: With lat = 0 the early opening is dropped in every mode, so the gate never opens before the read tick.
- R4: The late extension L is 0, 1, 4 or 6 ticks for extension mode 00, 01, 10 or 11 respectively (mode bits [1:0] as written by cfg_mode_i).
- R5: In counting mode the expected edge count is max(bl/2, 1). The gate goes low after tick te + L, where te is the tick carrying the last expected DQS rising edge.
- R6: In external mode the gate goes low after tick tc + L, where tc is a tick with ext_close_i high while the gate is open and no read is issued.
- R7: ext_close_i has no effect in counting mode, and DQS rising edges have no effect in external mode.
- R8: A read arriving while the gate is pending, open or in its late tail adds max(bl/2, 1) edges to the remaining count and keeps the gate open. Its own latency is ignored.
- R9: On clock edges with tick_i low, the gate output and all timing state hold, whatever the other inputs carry.
- R10: A cycle with cfg_wr_i high stores cfg_mode_i and cfg_cnt_en_i (1 = counting mode) for all reads issued afterwards.
- R11: DQS rising edges seen before the gate has opened are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Half-period step qualifier |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Extension mode to store |
| cfg_cnt_en_i | input | 1 | Counting mode select to store |
| rd_i | input | 1 | Read issued, sampled on ticks |
| rd_lat_i | input | LAT_W | Read latency in full clock periods |
| rd_bl_i | input | BL_W | Burst length in beats |
| dqs_rise_i | input | 1 | Synchronized DQS rising edge, one tick wide |
| ext_close_i | input | 1 | External gate close request |
| gate_o | output | 1 | Read DQS gate |

## Verification
The hardest case to reach is a read that lands exactly on the tick of a strobe edge while the gate is open. Both the decrement and the accumulation must apply in that tick, and the gate must not close even when that edge was the last one expected. The stimulus places the second read of a back-to-back pair on the first tick after opening, where the first strobe edge also falls. It mixes single-edge bursts with longer ones, so that the "last edge plus new read" collision occurs.

Stray strobe edges are also placed on the tick before opening. Idle-tick cycles are filled with reads, strobe edges and close pulses. Together these show that none of those inputs leak into the count.

// File: rtl/dqsg_pkg.sv
// Shared types and helpers for the DQS read gate generator.
// Assumes all timing is counted in half clock period ticks.
package dqsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OPEN = 2'd2,
        ST_TAIL = 2'd3
    } gate_st_e;

    localparam int TAIL_W = 3;

    // Late extension in ticks for each coded mode.
    function automatic logic [TAIL_W-1:0] late_ticks(input logic [1:0] mode);
        case (mode)
            2'b00:   late_ticks = 3'd0;
            2'b01:   late_ticks = 3'd1;
            2'b10:   late_ticks = 3'd4;
            default: late_ticks = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/dqsg_cfg.sv
// Configuration holder: extension mode and counting mode select.
// Assumes software changes it only while no read window is active.
module dqsg_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] mode_i,
    input  logic       cnt_en_i,
    output logic [1:0] mode_o,
    output logic       cnt_en_o
);
    // Capture configuration on a write; reset to no extension, counting on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= 2'b00;
            cnt_en_o <= 1'b1;
        end else if (wr_i) begin
            mode_o   <= mode_i;
            cnt_en_o <= cnt_en_i;
        end
    end

    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'b00) && cnt_en_o);
endmodule

// File: rtl/dqsg_timer.sv
// Loadable down counter reporting the step on which it reaches one.
// Assumes the owner loads a non-zero value before stepping it.
module dqsg_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic         expire_o
);
    logic [W-1:0] val_q;

    assign expire_o = step_i && (val_q == {{(W-1){1'b0}}, 1'b1});

    // Hold the remaining ticks; decrement on each step until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (load_i)
            val_q <= load_val_i;
        else if (step_i && val_q != '0)
            val_q <= val_q - 1'b1;
    end

    a_r2_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && val_q == '0) |=> val_q == '0);
endmodule

// File: rtl/dqsg_edge_cnt.sv
// Remaining DQS edge counter: loads, accumulates and decrements.
// Assumes EDGE_W is wide enough for the deepest expected burst chain; saturates.
module dqsg_edge_cnt #(
    parameter int BL_W   = 5,
    parameter int EDGE_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            add_i,
    input  logic [BL_W-1:0] bl_i,
    input  logic            dec_i,
    output logic            last_o,
    output logic            zero_o
);
    localparam logic [EDGE_W:0] SAT = {1'b0, {EDGE_W{1'b1}}};

    logic [EDGE_W-1:0] left_q;
    logic [EDGE_W:0]   per_rd;
    logic [EDGE_W:0]   sum;

    // Edges per read: half the burst, at least one.
    always_comb begin
        per_rd = (EDGE_W+1)'(bl_i >> 1);
        if (per_rd == '0)
            per_rd = (EDGE_W+1)'(1);
    end

    // Next remaining count from accumulate and decrement.
    always_comb begin
        sum = {1'b0, left_q};
        if (dec_i && left_q != '0)
            sum = sum - 1'b1;
        if (add_i)
            sum = sum + per_rd;
        if (sum > SAT)
            sum = SAT;
    end

    assign last_o = (left_q == {{(EDGE_W-1){1'b0}}, 1'b1});
    assign zero_o = (left_q == '0);

    // Track the edges still expected in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (load_i)
            left_q <= per_rd[EDGE_W-1:0];
        else
            left_q <= sum[EDGE_W-1:0];
    end

    a_r8_accum_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !load_i && !dec_i) |=> left_q >= $past(left_q));
endmodule

// File: rtl/dqs_gate_gen.sv
// Read DQS gate window generator for one byte lane.
// Opens the gate at the programmed latency (optionally half a period early,
// never before the read tick), closes it by edge counting or on an external
// request, then holds it for the mode's late extension.
// Assumes dqs_rise_i is synchronized and one tick wide, and that all inputs
// are meaningful only on clock edges where tick_i is high.
module dqs_gate_gen #(
    parameter int LAT_W  = 5,
    parameter int BL_W   = 5,
    parameter int EDGE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cfg_wr_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic             cfg_cnt_en_i,
    input  logic             rd_i,
    input  logic [LAT_W-1:0] rd_lat_i,
    input  logic [BL_W-1:0]  rd_bl_i,
    input  logic             dqs_rise_i,
    input  logic             ext_close_i,
    output logic             gate_o
);
    import dqsg_pkg::*;

    localparam int OPEN_W = LAT_W + 1;

    gate_st_e                st_q;
    logic [1:0]              mode;
    logic                    cnt_en;
    logic [TAIL_W-1:0]       late;
    logic [OPEN_W-1:0]       open_dly;
    logic                    early;
    logic                    rd_t;
    logic                    open_exp;
    logic                    tail_exp;
    logic                    edge_last;
    logic                    edge_zero;
    logic                    edge_dec;
    logic                    close_req;
    logic                    gate_q;

    dqsg_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr_i),
        .mode_i   (cfg_mode_i),
        .cnt_en_i (cfg_cnt_en_i),
        .mode_o   (mode),
        .cnt_en_o (cnt_en)
    );

    assign rd_t  = tick_i && rd_i;
    assign late  = late_ticks(mode);
    assign early = (mode != 2'b00) && (rd_lat_i != '0);

    // Opening delay in ticks: twice the latency, one less if early and allowed.
    assign open_dly = {rd_lat_i, 1'b0} - OPEN_W'(early);

    dqsg_timer #(.W(OPEN_W)) u_open_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (rd_t && st_q == ST_IDLE),
        .load_val_i (open_dly),
        .step_i     (tick_i && st_q == ST_WAIT),
        .expire_o   (open_exp)
    );

    dqsg_timer #(.W(TAIL_W)) u_tail_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tick_i && close_req && late != '0),
        .load_val_i (late),
        .step_i     (tick_i && st_q == ST_TAIL),
        .expire_o   (tail_exp)
    );

    assign edge_dec = tick_i && dqs_rise_i && cnt_en && st_q == ST_OPEN;

    dqsg_edge_cnt #(.BL_W(BL_W), .EDGE_W(EDGE_W)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_t && st_q == ST_IDLE),
        .add_i  (rd_t && st_q != ST_IDLE),
        .bl_i   (rd_bl_i),
        .dec_i  (edge_dec),
        .last_o (edge_last),
        .zero_o (edge_zero)
    );

    // Closing trigger while open: last counted edge or external request; a read wins.
    always_comb begin
        close_req = 1'b0;
        if (st_q == ST_OPEN && !rd_i) begin
            if (cnt_en)
                close_req = dqs_rise_i && edge_last;
            else
                close_req = ext_close_i;
        end
    end

    // Gate state machine, advancing only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            gate_q <= 1'b0;
        end else if (tick_i) begin
            case (st_q)
                ST_IDLE: begin
                    if (rd_i) begin
                        if (open_dly == '0) begin
                            st_q   <= ST_OPEN;
                            gate_q <= 1'b1;
                        end else begin
                            st_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (open_exp) begin
                        st_q   <= ST_OPEN;
                        gate_q <= 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (close_req) begin
                        if (late == '0) begin
                            st_q   <= ST_IDLE;
                            gate_q <= 1'b0;
                        end else begin
                            st_q <= ST_TAIL;
                        end
                    end
                end
                default: begin
                    if (rd_i) begin
                        st_q <= ST_OPEN;
                    end else if (tail_exp) begin
                        st_q   <= ST_IDLE;
                        gate_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign gate_o = gate_q;

    a_r3_no_open_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_t && st_q == ST_IDLE && rd_lat_i != '0) |=> !gate_o);

    a_r5_count_close: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q == ST_OPEN && cnt_en && dqs_rise_i && edge_last
         && !rd_i && mode == 2'b00) |=> !gate_o);

    a_r5_open_has_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && cnt_en) |-> !edge_zero);

    a_r7_ext_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q == ST_OPEN && cnt_en && !dqs_rise_i) |=> gate_o);

    a_r6_ext_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q == ST_OPEN && !cnt_en && ext_close_i && mode != 2'b00)
        |=> gate_o);

    a_r9_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !$past(!rst_n)) |=> $stable(gate_o));
endmodule

// File: tb/dqs_gate_gen_tb.sv
// Self-checking bench: directed corners plus seeded random read windows.
module dqs_gate_gen_tb;
    localparam int LAT_W = 5;
    localparam int BL_W  = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tick_i, cfg_wr_i, cfg_cnt_en_i, rd_i, dqs_rise_i, ext_close_i;
    logic [1:0]       cfg_mode_i;
    logic [LAT_W-1:0] rd_lat_i;
    logic [BL_W-1:0]  rd_bl_i;
    logic             gate_o;

    int total = 0;
    int bad   = 0;
    int cur_mode = 0;
    int cur_cnt  = 1;

    always #10 clk = ~clk;

    dqs_gate_gen #(.LAT_W(LAT_W), .BL_W(BL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
        .cfg_mode_i(cfg_mode_i), .cfg_cnt_en_i(cfg_cnt_en_i), .rd_i(rd_i),
        .rd_lat_i(rd_lat_i), .rd_bl_i(rd_bl_i), .dqs_rise_i(dqs_rise_i),
        .ext_close_i(ext_close_i), .gate_o(gate_o)
    );

    function automatic int late_of(input int m);
        case (m)
            0: return 0;
            1: return 1;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    function automatic int edges_of(input int bl);
        return (bl / 2 < 1) ? 1 : bl / 2;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s gate_o actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic tk, input logic rd, input int lat, input int bl,
                         input logic dq, input logic ec);
        @(negedge clk);
        tick_i = tk; rd_i = rd; rd_lat_i = LAT_W'(lat); rd_bl_i = BL_W'(bl);
        dqs_rise_i = dq; ext_close_i = ec;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input int m, input int c);
        @(negedge clk);
        tick_i = 1'b0; cfg_wr_i = 1'b1; cfg_mode_i = 2'(m); cfg_cnt_en_i = c[0];
        @(posedge clk);
        #1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        cur_mode = m; cur_cnt = c;
    endtask

    // One read window; optional second read (bl2 != 0) on the tick after opening.
    task automatic run_window(input int lat, input int bl, input int bl2,
                              input int ec_off, input string pre_tag);
        int early, open_t, late, ntot, close_t, tc, spur;
        string tag;
        early  = (cur_mode != 0 && lat != 0) ? 1 : 0;
        open_t = 2 * lat - early;
        late   = late_of(cur_mode);
        ntot   = edges_of(bl) + ((bl2 != 0) ? edges_of(bl2) : 0);
        tc     = open_t + 3 + ec_off;
        spur   = (open_t >= 2) ? open_t - 1 : -10;
        if (cur_cnt != 0) close_t = open_t + 1 + 2 * (ntot - 1) + late;
        else              close_t = tc + late;
        for (int t = 0; t <= close_t + 3; t++) begin
            logic rd, dq, ec, expv, prev;
            int   l, b;
            // Idle-tick noise cycles: everything must be ignored (R9).
            for (int n = 0; n < int'($urandom_range(0, 2)); n++) begin
                prev = (t - 1 >= open_t) && (t - 1 < close_t);
                drive(1'b0, 1'b1, 0, 2, 1'b1, 1'b1);
                check(gate_o, prev, "R9 idle tick");
            end
            rd = 1'b0; l = lat; b = bl;
            if (t == 0) rd = 1'b1;
            if (bl2 != 0 && t == open_t + 1) begin
                rd = 1'b1; b = bl2; l = int'($urandom_range(0, 9));
            end
            dq = 1'b0;
            if (t == spur) dq = 1'b1;
            for (int k = 0; k < ntot; k++)
                if (t == open_t + 1 + 2 * k) dq = 1'b1;
            if (cur_cnt != 0) ec = (t == open_t + 1) || (t == open_t + 2);
            else              ec = (t == tc);
            drive(1'b1, rd, l, b, dq, ec);
            expv = (t >= open_t) && (t < close_t);
            if (t <= open_t)
                tag = (lat == 0) ? {pre_tag, " R3 open"} : {pre_tag, " R2 open"};
            else if (t >= close_t - late && late != 0)
                tag = {pre_tag, " R4 late tail"};
            else if (bl2 != 0)
                tag = {pre_tag, " R8 accumulate"};
            else if (cur_cnt != 0)
                tag = {pre_tag, " R5 R7 R11 count close"};
            else
                tag = {pre_tag, " R6 R7 external close"};
            check(gate_o, expv, tag);
        end
    endtask

    initial begin
        #4_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5_9a7e));
        rst_n = 1'b0; tick_i = 1'b0; cfg_wr_i = 1'b0; cfg_mode_i = 2'b00;
        cfg_cnt_en_i = 1'b0; rd_i = 1'b0; rd_lat_i = '0; rd_bl_i = '0;
        dqs_rise_i = 1'b0; ext_close_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(gate_o, 1'b0, "R1 reset gate");
        // Defaults without any configuration write (R1).
        run_window(3, 4, 0, 0, "R1");
        // Configuration and zero-latency clamp corners (R10, R3).
        cfg_write(3, 0);
        run_window(0, 8, 0, 1, "R10");
        cfg_write(1, 1);
        run_window(0, 2, 0, 0, "R3");
        run_window(1, 1, 0, 0, "R5");
        // Last edge collides with a new read (R8).
        cfg_write(0, 1);
        run_window(2, 2, 4, 0, "R8");
        cfg_write(2, 1);
        run_window(2, 2, 2, 0, "R8");
        cfg_write(2, 0);
        run_window(1, 4, 8, 2, "R8");
        // Seeded random mix.
        for (int i = 0; i < 60; i++) begin
            int m, c, lat, bl, bl2;
            m   = int'($urandom_range(0, 3));
            c   = int'($urandom_range(0, 1));
            lat = int'($urandom_range(0, 6));
            bl  = 1 << $urandom_range(0, 4);
            bl2 = ($urandom_range(0, 2) == 0) ? (1 << $urandom_range(1, 3)) : 0;
            cfg_write(m, c);
            run_window(lat, bl, bl2, int'($urandom_range(0, 4)), "R4 R10");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule